// File: doc/BRIEF.md
# DRAM Cycle Type Monitor

A passive observer for an asynchronous DRAM strobe bus. The row strobe, the two byte-lane column strobes, the write enable and the output enable are all active low. They are sampled on a fast system clock. The monitor does not drive the bus. It follows each row-strobe-low period as one memory cycle and decides from the strobe edges what kind of cycle it was. The decision rests on which edge came first, how many samples separated the edges, and where the output enable stood while the write enable fell.

When the row strobe rises, the monitor emits a cycle type code with a one-clock valid pulse. Separate one-clock pulses report two kinds of problem: an output enable that is low while a late or read-modify-write cycle is writing, and a column strobe whose low pulse is too short. Every minimum separation is a clock-count parameter. The inputs are expected to be synchronous to the clock already.

Top module: `dram_cycle_monitor`

## Requirements
- R1: A cycle in which a column strobe fell and the write enable never fell reports type 0 (read).
- R2: When the write enable is low at the first column strobe fall of a cycle, the lead is the number of samples since it fell. A lead of at least WSETUP gives type 1 (early write). A shorter lead, including a fall in the same sample, gives type 5 (indeterminate).
- R3: Suppose the write enable first falls after the first column strobe fall, and the output enable was low at some sample of the cycle. If the row-to-write, column-to-write and strobe-to-write delays reach ROW_WR, COL_WR and STB_WR, the cycle reports type 2 (read-modify-write).
- R4: When the write enable first falls after a column strobe fall, with the output enable high at that sample and at every earlier sample of the cycle, the cycle reports type 3 (late write).
- R5: A write enable fall after a column strobe fall that meets neither R3 nor R4 gives type 5. So does a fall that comes while both column strobes have already risen again.
- R6: A cycle reports type 4 (refresh) in two cases: some column strobe was low in the sample before the row strobe fell, or no column strobe fell during the cycle. In a refresh cycle the write and output enables are ignored and never raise oe_err.
- R7: The row-to-write delay counts from the row strobe fall. The column-to-write delay counts from the first column strobe fall. The strobe-to-write delay counts from the last column strobe fall. A later byte-lane strobe therefore shortens the last delay.
- R8: In a type 2 or type 3 cycle, oe_err pulses for one clock, at most once per cycle, in the clock after the first sample in which the write enable and the output enable are both low.
- R9: cyc_valid is high for exactly the clock after the sample in which the row strobe is seen rising, and cyc_type holds the code of that cycle.
- R10: When column strobe i rises after being low for fewer than STB_MINW samples, stb_width_err[i] pulses for the following clock. Bit 0 is the low byte lane and bit 1 the high byte lane.
- R11: During and after reset, with all strobes high, cyc_valid, oe_err and stb_width_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 2 | Column strobes, bit 0 low byte, bit 1 high byte, active low |
| wr_n | input | 1 | Write enable, active low |
| outen_n | input | 1 | Output enable, active low |
| cyc_valid | output | 1 | One-clock pulse at the end of each cycle |
| cyc_type | output | 3 | 0 read, 1 early write, 2 read-modify-write, 3 late write, 4 refresh, 5 indeterminate |
| oe_err | output | 1 | Output enable low during a late or read-modify-write |
| stb_width_err | output | 2 | Per-lane short column strobe pulse |

## Verification
The end-of-cycle report and a strobe width error can land in the same clock. That happens when a too-short column strobe pulse ends in the same sample as the row strobe rise. The bench provokes it by raising both column strobes and the row strobe in one drive, after only two low samples. It then requires that cyc_valid (type 0) and both stb_width_err bits were seen together at one sampling point, with neither report lost.

// File: rtl/dram_cycle_monitor.sv
module dram_cycle_monitor #(
  parameter int CW       = 8,
  parameter int WSETUP   = 2,
  parameter int ROW_WR   = 6,
  parameter int COL_WR   = 4,
  parameter int STB_WR   = 3,
  parameter int STB_MINW = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       row_stb_n,
  input  logic [1:0] col_stb_n,
  input  logic       wr_n,
  input  logic       outen_n,
  output logic       cyc_valid,
  output logic [2:0] cyc_type,
  output logic       oe_err,
  output logic [1:0] stb_width_err
);
  localparam logic [2:0] TY_READ = 3'd0, TY_EARLY = 3'd1, TY_RMW = 3'd2,
                         TY_LATE = 3'd3, TY_REF = 3'd4, TY_INDET = 3'd5;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] x);
    return (x == CMAX) ? x : x + 1'b1;
  endfunction

  logic          p_row, p_wr;
  logic [1:0]    p_col;
  logic [CW-1:0] row_age, first_age, last_age, wr_age;
  logic [CW-1:0] stb_age [2];
  logic          cas_seen, hid, wr_done, oe_seen, oe_err_seen;
  logic [2:0]    ty;

  wire       active    = ~row_stb_n;
  wire       row_fall  = p_row & ~row_stb_n;
  wire       row_rise  = ~p_row & row_stb_n;
  wire [1:0] col_fall  = p_col & ~col_stb_n;
  wire       hid_now   = row_fall & ~&p_col;
  wire       hid_eff   = hid | hid_now;
  wire       wr_fall   = p_wr & ~wr_n;
  wire       first_fall = active & ~cas_seen & ~hid_eff & |col_fall;
  wire       late_fall  = active & cas_seen & ~hid & ~wr_done & wr_fall;
  wire       lead_ok    = ~wr_fall & (wr_age >= CW'(WSETUP));
  wire       delays_ok  = (row_age >= CW'(ROW_WR)) & (first_age >= CW'(COL_WR)) &
                          (last_age >= CW'(STB_WR));

  logic [2:0] ty_we;
  always_comb begin
    if (&col_stb_n)               ty_we = TY_INDET;
    else if (~oe_seen & outen_n)  ty_we = TY_LATE;
    else if (delays_ok)           ty_we = TY_RMW;
    else                          ty_we = TY_INDET;
  end

  wire wr_kind  = cas_seen & wr_done & ((ty == TY_RMW) | (ty == TY_LATE));
  wire oe_err_c = active & ~hid & ~wr_n & ~outen_n & ~oe_err_seen &
                  ((late_fall & (ty_we == TY_RMW)) | wr_kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_row <= 1'b1; p_wr <= 1'b1; p_col <= 2'b11;
      row_age <= '0; first_age <= '0; last_age <= '0; wr_age <= '0;
      cas_seen <= 1'b0; hid <= 1'b0; wr_done <= 1'b0; oe_seen <= 1'b0;
      oe_err_seen <= 1'b0; ty <= TY_READ;
      cyc_valid <= 1'b0; cyc_type <= TY_READ; oe_err <= 1'b0;
    end else begin
      p_row <= row_stb_n; p_wr <= wr_n; p_col <= col_stb_n;
      row_age   <= row_fall    ? CW'(1) : sat_inc(row_age);
      first_age <= first_fall  ? CW'(1) : sat_inc(first_age);
      last_age  <= (|col_fall) ? CW'(1) : sat_inc(last_age);
      wr_age    <= wr_fall     ? CW'(1) : sat_inc(wr_age);
      oe_err    <= oe_err_c;
      cyc_valid <= row_rise;
      if (row_rise) cyc_type <= (hid | ~cas_seen) ? TY_REF : ty;
      if (row_rise) begin
        cas_seen <= 1'b0; hid <= 1'b0; wr_done <= 1'b0;
        oe_seen <= 1'b0; oe_err_seen <= 1'b0; ty <= TY_READ;
      end else if (active) begin
        if (hid_now) hid <= 1'b1;
        if (~outen_n) oe_seen <= 1'b1;
        if (oe_err_c) oe_err_seen <= 1'b1;
        if (first_fall) begin
          cas_seen <= 1'b1;
          if (~wr_n) begin
            wr_done <= 1'b1;
            ty <= lead_ok ? TY_EARLY : TY_INDET;
          end else begin
            ty <= TY_READ;
          end
        end else if (late_fall) begin
          wr_done <= 1'b1;
          ty <= ty_we;
        end
      end
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stb_age[i] <= '0;
        stb_width_err[i] <= 1'b0;
      end else begin
        stb_age[i] <= col_fall[i] ? CW'(1) : sat_inc(stb_age[i]);
        stb_width_err[i] <= ~p_col[i] & col_stb_n[i] & (stb_age[i] < CW'(STB_MINW));
      end
    end
  end
endmodule

// File: rtl/dram_cycle_monitor_chk.sv
module dram_cycle_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       row_stb_n,
  input logic [1:0] col_stb_n,
  input logic       wr_n,
  input logic       outen_n,
  input logic       cyc_valid,
  input logic [2:0] cyc_type,
  input logic       oe_err,
  input logic [1:0] stb_width_err
);
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> !cyc_valid);
  // R9
  valid_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> $past(row_stb_n));
  // R9
  type_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> (cyc_type <= 3'd5));
  // R8
  oe_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_err |-> $past(!wr_n && !outen_n && !row_stb_n));
  // R8
  oe_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_err |=> !oe_err);
  // R10
  lo_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_width_err[0] |-> $past(col_stb_n[0]));
  // R10
  hi_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_width_err[1] |-> $past(col_stb_n[1]));
endmodule

bind dram_cycle_monitor dram_cycle_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
  .wr_n(wr_n), .outen_n(outen_n), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
  .oe_err(oe_err), .stb_width_err(stb_width_err)
);

// File: tb/tb_dram_cycle_monitor.sv
`timescale 1ns/1ps
module tb_dram_cycle_monitor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic row_stb_n = 1'b1, wr_n = 1'b1, outen_n = 1'b1;
  logic [1:0] col_stb_n = 2'b11;
  logic cyc_valid, oe_err;
  logic [2:0] cyc_type;
  logic [1:0] stb_width_err;

  always #4 clk = ~clk;

  dram_cycle_monitor dut (
    .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .wr_n(wr_n), .outen_n(outen_n), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
    .oe_err(oe_err), .stb_width_err(stb_width_err)
  );

  int errors = 0, checks = 0;
  int n_valid, n_oe, n_w0, n_w1, n_both;
  logic [2:0] first_type, last_type;
  bit done = 0;

  always @(negedge clk) if (rst_n) begin
    if (cyc_valid) begin
      if (n_valid == 0) first_type = cyc_type;
      last_type = cyc_type;
      n_valid++;
    end
    if (oe_err) n_oe++;
    if (stb_width_err[0]) n_w0++;
    if (stb_width_err[1]) n_w1++;
    if (cyc_valid && stb_width_err == 2'b11) n_both++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    n_valid = 0; n_oe = 0; n_w0 = 0; n_w1 = 0; n_both = 0;
    first_type = 3'd7; last_type = 3'd7;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_cycle(input string tag, input int ty, input int oe);
    chk(n_valid == 1, {tag, " valid count"}, n_valid, 1);
    chk(last_type == 3'(ty), {tag, " type"}, last_type, ty);
    chk(n_oe == oe, {tag, " oe_err count"}, n_oe, oe);
  endtask

  task automatic t_reset();
    chk(cyc_valid == 0 && oe_err == 0 && stb_width_err == 0, "R11 reset outputs",
        {cyc_valid, oe_err, stb_width_err}, 0);
  endtask

  task automatic t_read();
    clr();
    row_stb_n = 0; tick(3);
    col_stb_n = 2'b00; outen_n = 0; tick(4);
    col_stb_n = 2'b11; outen_n = 1; tick(1);
    row_stb_n = 1; tick(1);
    chk(cyc_valid == 1 && cyc_type == 3'd0, "R9 valid right after rise", cyc_valid, 1);
    tick(1);
    chk(cyc_valid == 0, "R9 valid one clock", cyc_valid, 0);
    tick(3);
    expect_cycle("R1 read", 0, 0);
  endtask

  task automatic t_early(input int lead, input int ty, input string tag);
    clr();
    row_stb_n = 0; tick(1);
    wr_n = 0; tick(lead);
    col_stb_n = 2'b00; tick(4);
    col_stb_n = 2'b11; tick(1);
    wr_n = 1; row_stb_n = 1; tick(4);
    expect_cycle(tag, ty, 0);
  endtask

  task automatic t_rmw(input bit oe_bad, input bit split, input int ty, input string tag);
    clr();
    row_stb_n = 0; tick(2);
    if (split) col_stb_n = 2'b10; else col_stb_n = 2'b00;
    outen_n = 0; tick(4);
    col_stb_n = 2'b00; tick(1);
    if (!oe_bad) outen_n = 1; tick(1);
    wr_n = 0; tick(3);
    outen_n = 1; col_stb_n = 2'b11; tick(1);
    wr_n = 1; row_stb_n = 1; tick(4);
    expect_cycle(tag, ty, oe_bad ? 1 : 0);
  endtask

  task automatic t_late(input bit oe_bad, input string tag);
    clr();
    row_stb_n = 0; tick(1);
    col_stb_n = 2'b00; tick(1);
    wr_n = 0; tick(2);
    if (oe_bad) outen_n = 0; tick(2);
    outen_n = 1; col_stb_n = 2'b11; tick(1);
    wr_n = 1; row_stb_n = 1; tick(4);
    expect_cycle(tag, 3, oe_bad ? 1 : 0);
  endtask

  task automatic t_indet_short();
    clr();
    row_stb_n = 0; tick(1);
    col_stb_n = 2'b00; outen_n = 0; tick(2);
    outen_n = 1; wr_n = 0; tick(3);
    col_stb_n = 2'b11; tick(1);
    wr_n = 1; row_stb_n = 1; tick(4);
    expect_cycle("R5 delays short", 5, 0);
  endtask

  task automatic t_indet_after();
    clr();
    row_stb_n = 0; tick(1);
    col_stb_n = 2'b00; tick(4);
    col_stb_n = 2'b11; tick(1);
    wr_n = 0; tick(2);
    wr_n = 1; row_stb_n = 1; tick(4);
    expect_cycle("R5 write after strobes rose", 5, 0);
  endtask

  task automatic t_cbr();
    clr();
    col_stb_n = 2'b00; tick(2);
    row_stb_n = 0; tick(4);
    col_stb_n = 2'b11; tick(1);
    row_stb_n = 1; tick(4);
    expect_cycle("R6 strobe-before-row refresh", 4, 0);
  endtask

  task automatic t_row_only();
    clr();
    row_stb_n = 0; wr_n = 0; tick(5);
    row_stb_n = 1; wr_n = 1; tick(4);
    expect_cycle("R6 row-only refresh", 4, 0);
  endtask

  task automatic t_hidden();
    clr();
    row_stb_n = 0; tick(1);
    wr_n = 0; tick(3);
    col_stb_n = 2'b00; tick(4);
    row_stb_n = 1; tick(2);
    row_stb_n = 0; outen_n = 1; tick(5);
    row_stb_n = 1; tick(2);
    col_stb_n = 2'b11; wr_n = 1; tick(4);
    chk(n_valid == 2, "R6 hidden two reports", n_valid, 2);
    chk(first_type == 3'd1, "R2 write before hidden refresh", first_type, 1);
    chk(last_type == 3'd4, "R6 hidden refresh type", last_type, 4);
    chk(n_oe == 0, "R6 hidden no oe_err", n_oe, 0);
  endtask

  task automatic t_width();
    clr();
    row_stb_n = 0; tick(1);
    col_stb_n = 2'b10; tick(2);
    col_stb_n = 2'b01; tick(3);
    col_stb_n = 2'b11; tick(1);
    row_stb_n = 1; tick(4);
    chk(n_w0 == 1, "R10 low lane short", n_w0, 1);
    chk(n_w1 == 0, "R10 high lane at minimum", n_w1, 0);
    expect_cycle("R1 split read", 0, 0);
  endtask

  task automatic t_collide();
    clr();
    row_stb_n = 0; tick(2);
    col_stb_n = 2'b00; tick(2);
    col_stb_n = 2'b11; row_stb_n = 1; tick(4);
    chk(n_both == 1, "R10 width error with report same clock", n_both, 1);
    expect_cycle("R9 collide", 0, 0);
  endtask

  initial begin
    clr();
    tick(3);
    t_reset();
    rst_n = 1; tick(2);
    t_reset();
    t_read();
    t_early(3, 1, "R2 early write");
    t_early(1, 5, "R2 short lead");
    t_rmw(0, 0, 2, "R3 rmw");
    t_rmw(1, 0, 2, "R8 rmw oe low");
    t_rmw(0, 1, 5, "R7 late lane shortens delay");
    t_late(0, "R4 late write");
    t_late(1, "R8 late oe low");
    t_indet_short();
    t_indet_after();
    t_cbr();
    t_row_only();
    t_hidden();
    t_width();
    t_collide();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule